// File: doc/BRIEF.md
# Programmable Resolution Watchdog Timer

This block is a host-programmed watchdog. The host writes one byte that sets three things: a 5-bit multiplier, a 2-bit coarse resolution code and an output steering bit. From that byte the block counts down a timeout. A 16 Hz base tick from the clock core paces the countdown. The host has to rewrite the control byte before the timeout runs out. If it does not, the watchdog expires.

On expiry a sticky watchdog flag is set. The steering bit then picks one of two actions. The first raises an interrupt line that stays up until the host reads the flags byte. The second emits a fixed-length reset pulse and clears the control byte, which leaves the watchdog disarmed. Writing a multiplier of zero disables the watchdog completely. All host access goes through a small byte-wide register window with separate read and write strobes.

Top module: `prog_wdt`

## Requirements
- R1: After reset the control byte reads 0x00, the flags byte reads 0x00, and both the interrupt and the reset output are low.
- R2: A write to index 7 stores the control byte, which reads back unchanged from index 7. Bit 7 is the steering bit, bits 6..2 are the multiplier and bits 1..0 are the resolution code.
- R3: The timeout in base ticks is the multiplier times 1, 4, 16 or 64, for resolution codes 0, 1, 2 and 3. The flag becomes visible in the cycle after the tick that completes the timeout.
- R4: With a multiplier of zero, no number of ticks causes an expiry.
- R5: Every write to index 7 reloads the count from the written value and restarts the countdown, including a write of the same value.
- R6: Expiry sets bit 7 of the flags byte at index 0. The flag holds until a read strobe at index 0, and that read returns 0x80 and clears the flag.
- R7: With steering 0, expiry raises the interrupt output. It stays high until the flags byte is read. The countdown then restarts with the same setting.
- R8: With steering 1, expiry drives the reset output high for exactly RST_LEN cycles, starting the cycle after the expiring tick. The control byte is cleared to 0x00 and the interrupt stays low.
- R9: Indices other than 0 and 7 read as 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16hz | input | 1 | One-cycle pulse at the 16 Hz base rate |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the flag when reading index 0) |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed index |
| wdt_irq | output | 1 | Interrupt, held until the flags byte is read |
| wdt_rst_out | output | 1 | Reset pulse of RST_LEN cycles |

## Verification
The bench sweeps every multiplier at the two finest resolutions and a spread of multipliers at the coarser ones. It counts the ticks to the flag and compares the count with multiplier times four to the power of the code. An off-by-one in the countdown, or a wrong shift for a code, shows up as a miscount. Other tests target these faults:
- A design that does not really disable on a zero multiplier would wrap its count and fire during a long run of ticks.
- A rewrite that does not reload the count would fire early.
- A reset-steered expiry that leaves the control byte armed would fire again.
- A pulse of the wrong length would be caught by counting the reset cycles.
- A flag that clears without a read, or survives one, would be seen through the flags byte.

// File: rtl/prog_wdt_pkg.sv
package prog_wdt_pkg;
  localparam int MULT_W    = 5;
  localparam int RES_W     = 2;
  localparam int RES_STEPS = 1 << RES_W;
  localparam int CNT_W     = MULT_W + 2 * (RES_STEPS - 1);
  localparam int CFG_W     = 1 + MULT_W + RES_W;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdt_cfg_t;

  // timeout in base ticks: multiplier scaled by 4^res
  function automatic logic [CNT_W-1:0] span_ticks(input logic [MULT_W-1:0] m,
                                                  input logic [RES_W-1:0]  r);
    span_ticks = CNT_W'(m) << (2 * r);
  endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import prog_wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_cfg,
  input  wdt_cfg_t wdata,
  input  logic     clr_cfg,
  output wdt_cfg_t cfg
);
  // a host write outranks the self-clear of a reset-steered expiry
  always_ff @(posedge clk) begin
    if (!rst_n)       cfg <= '0;
    else if (wr_cfg)  cfg <= wdata;
    else if (clr_cfg) cfg <= '0;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import prog_wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     load,
  input  wdt_cfg_t load_cfg,
  input  wdt_cfg_t cfg,
  output logic     expire
);
  logic [CNT_W-1:0] count;
  logic             armed;

  assign armed  = (cfg.mult != '0);
  assign expire = tick && armed && !load && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= span_ticks(load_cfg.mult, load_cfg.res);
    else if (tick && armed) begin
      if (count == CNT_W'(1)) count <= span_ticks(cfg.mult, cfg.res);
      else                    count <= count - CNT_W'(1);
    end
  end

  // R5: after a reload the count is never zero while armed
  p_reload_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_cfg.mult != '0) |=> (count != '0));
endmodule

// File: rtl/wdt_events.sv
module wdt_events #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic flag_rd,
  output logic flag,
  output logic irq,
  output logic rst_out
);
  localparam int PW = $clog2(RST_LEN + 1);
  logic [PW-1:0] pulse_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag       <= 1'b0;
      irq        <= 1'b0;
      pulse_left <= '0;
    end else begin
      if (expire)       flag <= 1'b1;
      else if (flag_rd) flag <= 1'b0;

      if (expire && !steer) irq <= 1'b1;
      else if (flag_rd)     irq <= 1'b0;

      if (expire && steer)     pulse_left <= PW'(RST_LEN);
      else if (pulse_left != 0) pulse_left <= pulse_left - PW'(1);
    end
  end

  assign rst_out = (pulse_left != '0);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !expire) |=> (!irq && !flag));
  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && steer) |=> rst_out);
  p_no_irq_on_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && steer && !irq) |=> !irq);
endmodule

// File: rtl/prog_wdt.sv
module prog_wdt
  import prog_wdt_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int FLAG_IDX = 0,
  parameter int CFG_IDX  = 7,
  parameter int RST_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16hz,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_out
);
  wdt_cfg_t cfg_q, cfg_in;
  logic     wr_cfg, flag_rd, expire, flag_q;

  assign cfg_in  = wdt_cfg_t'(bus_wdata[CFG_W-1:0]);
  assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(CFG_IDX));
  assign flag_rd = bus_rd && (bus_addr == ADDR_W'(FLAG_IDX));

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wdata(cfg_in),
    .clr_cfg(expire && cfg_q.steer), .cfg(cfg_q)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_16hz), .load(wr_cfg),
    .load_cfg(cfg_in), .cfg(cfg_q), .expire(expire)
  );

  wdt_events #(.RST_LEN(RST_LEN)) u_evt (
    .clk(clk), .rst_n(rst_n), .expire(expire), .steer(cfg_q.steer),
    .flag_rd(flag_rd), .flag(flag_q), .irq(wdt_irq), .rst_out(wdt_rst_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(FLAG_IDX))     bus_rdata[DATA_W-1] = flag_q;
    else if (bus_addr == ADDR_W'(CFG_IDX)) bus_rdata[CFG_W-1:0] = cfg_q;
  end

  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mult == '0) |-> !expire);
  p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg_q.steer && !wr_cfg) |=> (cfg_q == '0));
  p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (cfg_q == $past(cfg_in)));
endmodule

// File: tb/prog_wdt_tb.sv
module prog_wdt_tb;
  localparam int RST_LEN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16hz = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       wdt_irq, wdt_rst_out;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  prog_wdt #(.RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_rst_out(wdt_rst_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 3'd0;
  endtask

  // read with strobe; returns data seen during the strobe cycle
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; bus_addr = 3'd0;
  endtask

  // look at a register without the read strobe
  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata; bus_addr = 3'd0;
  endtask

  task automatic tick();
    @(negedge clk); tick_16hz = 1'b1;
    @(negedge clk); tick_16hz = 1'b0;
    @(negedge clk);
  endtask

  // ticks until the flag shows, capped at lim
  task automatic ticks_to_flag(input int lim, output int n);
    logic [7:0] d;
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      peek(3'd0, d);
      if (d[7]) begin n = i; break; end
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, t, hi;
    int mlist[5] = '{1, 2, 5, 17, 31};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    peek(3'd7, d); check("R1 cfg", d, 0);
    peek(3'd0, d); check("R1 flags", d, 0);
    check("R1 irq", wdt_irq, 0);
    check("R1 rst", wdt_rst_out, 0);

    // R2 readback
    wr(3'd7, 8'h5A); peek(3'd7, d); check("R2 readback", d, 8'h5A);
    wr(3'd7, 8'h00);

    // R3 sweep, steering 0
    for (int r = 0; r < 4; r++) begin
      for (int m = 1; m < 32; m++) begin
        if (r >= 2) begin
          bit hit = 0;
          foreach (mlist[k]) if (mlist[k] == m && (r == 2 || m == 1 || m == 31)) hit = 1;
          if (!hit) continue;
        end
        t = m * (1 << (2 * r));
        wr(3'd7, 8'(m << 2 | r));
        ticks_to_flag(t + 2, n);
        check($sformatf("R3 m=%0d r=%0d", m, r), n, t);
        rd(3'd0, d);
      end
    end
    wr(3'd7, 8'h00);

    // R4 zero multiplier, every resolution
    for (int r = 0; r < 4; r++) begin
      wr(3'd7, 8'(r));
      ticks_to_flag(80, n);
      check("R4 disabled", n, 0);
    end

    // R5 rewrite restarts
    wr(3'd7, 8'h10);           // m=4 r=0
    repeat (3) tick();
    wr(3'd7, 8'h10);
    ticks_to_flag(3, n); check("R5 no early expiry", n, 0);
    ticks_to_flag(1, n); check("R5 expiry after reload", n, 1);

    // R6 flag sticky until read; read returns 0x80 and clears
    repeat (5) @(negedge clk);
    peek(3'd0, d); check("R6 flag held", d, 8'h80);
    rd(3'd0, d);   check("R6 read value", d, 8'h80);
    peek(3'd0, d); check("R6 cleared", d, 0);

    // R7 irq until read, periodic restart
    wr(3'd7, 8'h08);           // m=2 r=0
    ticks_to_flag(4, n); check("R7 first expiry", n, 2);
    check("R7 irq high", wdt_irq, 1);
    repeat (4) @(negedge clk);
    check("R7 irq held", wdt_irq, 1);
    rd(3'd0, d);
    check("R7 irq cleared", wdt_irq, 0);
    ticks_to_flag(4, n); check("R7 restart", n, 2);
    rd(3'd0, d);
    wr(3'd7, 8'h00);

    // R8 reset steering
    wr(3'd7, 8'h8C);           // steer=1 m=3 r=0
    tick(); tick();
    @(negedge clk); tick_16hz = 1'b1;
    @(negedge clk); tick_16hz = 1'b0;
    hi = 0;
    while (wdt_rst_out && hi < 50) begin
      hi++;
      check("R8 no irq", wdt_irq, 0);
      @(negedge clk);
    end
    check("R8 pulse length", hi, RST_LEN);
    peek(3'd7, d); check("R8 cfg cleared", d, 0);
    peek(3'd0, d); check("R8 flag", d, 8'h80);
    rd(3'd0, d);
    ticks_to_flag(10, n); check("R8 disarmed", n, 0);

    // R9 other indices
    wr(3'd7, 8'h24);
    for (int a = 1; a < 7; a++) begin
      wr(3'(a), 8'hFF);
      peek(3'(a), d); check($sformatf("R9 idx %0d", a), d, 0);
    end
    peek(3'd7, d); check("R9 cfg untouched", d, 8'h24);
    peek(3'd0, d); check("R9 flags untouched", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule